// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small byte-addressed nonvolatile memory of 128 locations. It oversamples the bus lines with the system clock, detects START and STOP conditions, and recognises a fixed four-bit device-type code in the first byte of a transfer. When selected for a write, it takes a word address and data bytes. When selected for a read, it sends bytes from its internal address pointer. It acknowledges, and sends data, by driving an open-drain output enable for SDA.

A received data byte is only held pending while the transfer is in progress. It is written into the array when the master issues STOP. A busy window of a set number of system clocks follows. During that window the target ignores its own address, so a master can poll with address bytes until it gets an acknowledge. A read goes on byte after byte for as long as the master acknowledges. A missing acknowledge makes the target release the bus and stay silent until STOP.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, sda_oe_o is low and every array location reads 0xFF.
- R2: START (SDA falling while SCL is high) starts reception of a device byte. STOP (SDA rising while SCL is high) returns the target to idle with SDA released. Clock pulses received outside a START-framed transfer draw no acknowledge.
- R3: The device byte is received MSB first. The target acknowledges it only when bits 7:4 equal 1010. Bits 3:1 are don't-care. Bit 0 selects the direction: 0 is write, 1 is read. On a mismatch the target does not acknowledge and stays silent until the next START.
- R4: The acknowledge holds sda_oe_o high from the SCL falling edge after the eighth bit to the SCL falling edge after the ninth bit. sda_oe_o never changes while SCL is high.
- R5: In a write, the target acknowledges the word-address byte and every data byte. Bit 7 of the word address is ignored, and bits 6:0 load the address pointer.
- R6: A data byte is held pending, and the array stays unchanged until STOP. On STOP the pending byte is written at its address. Each data byte advances the pointer by one and replaces any earlier pending byte.
- R7: A repeated START before STOP discards the pending byte. Nothing is written and no busy window starts.
- R8: For BUSY_CYCLES system clocks after a write is committed, the target does not acknowledge its device byte. After that window it acknowledges again.
- R9: A read sends bytes MSB first, starting at the pointer. The pointer increments after each byte. A master acknowledge is followed by the byte at the next address, and addresses wrap from 127 to 0.
- R10: If the master does not acknowledge a read byte, the target releases SDA and drives nothing more until STOP. A new transfer after STOP works normally.
- R11: A read that is not preceded by a word address in the same transfer starts at the pointer left by the previous operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When high, pulls SDA low (open-drain drive) |

## Verification
The bench polls the target right after a write commits and expects no acknowledge; a design that ignored the busy window, or committed before STOP, would acknowledge at once or return the new data too early. It reads across address 127 with master acknowledges, so a pointer that saturated or restarted from the word address would return the wrong second byte. After a master NACK it clocks a further byte with SDA released and watches the output enable; a design that kept transmitting would pull SDA low during that byte. It breaks a write with a repeated START and sets bit 7 of the word address, which catches designs that commit an aborted byte or decode eight address bits.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_READ,
    ST_WAIT_STOP
  } eep_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q, rise_q, fall_q;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  end

  // level follows the synchronized line only after FILT_LEN agreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (sync_out != level_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          level_q <= sync_out;
          rise_q  <= sync_out;
          fall_q  <= ~sync_out;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/i2c_eep_bus_if.sv
module i2c_eep_bus_if #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, rise, fall;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  assign scl_o      = lvl[0];
  assign scl_rise_o = rise[0];
  assign scl_fall_o = fall[0];
  assign sda_o      = lvl[1];
  // both lines pass the same delay, so SCL level here matches the SDA edge
  assign start_o    = fall[1] & lvl[0];
  assign stop_o     = rise[1] & lvl[0];
endmodule

// File: rtl/i2c_eep_store.sv
module i2c_eep_store #(
  parameter int ADDR_W      = 7,
  parameter int BUSY_CYCLES = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [BW-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
    end else if (commit_i) begin
      busy_cnt_q <= BW'(BUSY_CYCLES);
    end else if (busy_cnt_q != '0) begin
      busy_cnt_q <= busy_cnt_q - BW'(1);
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = (busy_cnt_q != '0);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eep_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         BUSY_CYCLES = 500,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic busy, commit;
  logic [7:0] rd_data;

  eep_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic              ack_ph_q, oe_q, mack_q, pend_vld_q;
  logic [7:0]        shreg_q, tx_q, pend_data_q;
  logic [ADDR_W-1:0] ptr_q, pend_addr_q;

  i2c_eep_bus_if #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .sda_o     (sda_lvl),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  assign commit = stop_det & pend_vld_q;

  i2c_eep_store #(
    .ADDR_W     (ADDR_W),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .wr_addr_i(pend_addr_q),
    .wr_data_i(pend_data_q),
    .rd_addr_i(ptr_q),
    .rd_data_o(rd_data),
    .busy_o   (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      ack_ph_q    <= 1'b0;
      oe_q        <= 1'b0;
      mack_q      <= 1'b0;
      pend_vld_q  <= 1'b0;
      shreg_q     <= '0;
      tx_q        <= '0;
      pend_data_q <= '0;
      ptr_q       <= '0;
      pend_addr_q <= '0;
    end else if (start_det) begin
      // repeated START also drops an uncommitted byte
      state_q    <= ST_DEV;
      bit_cnt_q  <= '0;
      ack_ph_q   <= 1'b0;
      oe_q       <= 1'b0;
      pend_vld_q <= 1'b0;
    end else if (stop_det) begin
      state_q    <= ST_IDLE;
      ack_ph_q   <= 1'b0;
      oe_q       <= 1'b0;
      pend_vld_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && !ack_ph_q) begin
            shreg_q   <= {shreg_q[6:0], sda_lvl};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          if (scl_fall) begin
            if (!ack_ph_q && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (shreg_q[7:4] == DEV_CODE && !busy) begin
                  ack_ph_q <= 1'b1;
                  oe_q     <= 1'b1;
                end else begin
                  state_q <= ST_WAIT_STOP;
                end
              end else begin
                ack_ph_q <= 1'b1;
                oe_q     <= 1'b1;
                if (state_q == ST_WADDR) begin
                  ptr_q <= shreg_q[ADDR_W-1:0];
                end else begin
                  pend_data_q <= shreg_q;
                  pend_addr_q <= ptr_q;
                  pend_vld_q  <= 1'b1;
                  ptr_q       <= ptr_q + ADDR_W'(1);
                end
              end
            end else if (ack_ph_q) begin
              ack_ph_q <= 1'b0;
              oe_q     <= 1'b0;
              if (state_q == ST_DEV) begin
                if (shreg_q[0]) begin
                  state_q <= ST_READ;
                  tx_q    <= rd_data;
                  ptr_q   <= ptr_q + ADDR_W'(1);
                  oe_q    <= ~rd_data[7];
                end else begin
                  state_q <= ST_WADDR;
                end
              end else if (state_q == ST_WADDR) begin
                state_q <= ST_WDATA;
              end
            end
          end
        end
        ST_READ: begin
          if (!ack_ph_q) begin
            if (scl_rise) bit_cnt_q <= bit_cnt_q + 4'd1;
            if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                oe_q      <= 1'b0;
                ack_ph_q  <= 1'b1;
                bit_cnt_q <= '0;
              end else begin
                oe_q <= ~tx_q[~bit_cnt_q[2:0]];
              end
            end
          end else begin
            if (scl_rise) mack_q <= ~sda_lvl;
            if (scl_fall) begin
              ack_ph_q <= 1'b0;
              if (mack_q) begin
                tx_q  <= rd_data;
                ptr_q <= ptr_q + ADDR_W'(1);
                oe_q  <= ~rd_data[7];
              end else begin
                state_q <= ST_WAIT_STOP;
                oe_q    <= 1'b0;
              end
            end
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_eep_checker.sv
module i2c_eep_checker
  import i2c_eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_lvl_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       busy_i,
  input logic       sda_oe_i,
  input eep_state_e state_i
);
  AST_START_ENTERS_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == ST_DEV && !sda_oe_i)); // R2

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == ST_IDLE && !sda_oe_i)); // R2

  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(scl_lvl_i && !start_i && !stop_i) |-> $stable(sda_oe_i)); // R4

  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i)); // R6

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DEV && $rose(sda_oe_i)) |-> !$past(busy_i)); // R8

  AST_QUIET_AFTER_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT_STOP) |-> !sda_oe_i); // R10
endmodule

bind i2c_eeprom_target i2c_eep_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_lvl_i(scl_lvl),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .busy_i   (busy),
  .sda_oe_i (sda_oe_o),
  .state_i  (state_q)
);

// File: tb/i2c_eeprom_target_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_target_bench;
  localparam int BUSY = 500;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int viol    = 0;
  bit watch_oe = 1'b0;
  bit oe_seen  = 1'b0;
  logic scl_d = 1'b1, oe_d = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) u_i2c_eeprom_target (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe)
  );

  // R4 monitor: output enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_ni && scl_m && scl_d && (sda_oe !== oe_d)) viol++;
    if (watch_oe && sda_oe) oe_seen = 1'b1;
    scl_d = scl_m;
    oe_d  = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    wq();
    sda_m = ~ack; wq();
    scl_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic wait_busy();
    repeat (BUSY + 50) @(posedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [6:0] a, input logic [7:0] d, input bit msb, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA0, ack); check(ack, {req, " dev ack"}, ack, 1);
    send_byte({msb, a}, ack); check(ack, {req, " waddr ack"}, ack, 1);
    send_byte(d, ack); check(ack, {req, " data ack"}, ack, 1);
    i2c_stop();
  endtask

  task automatic rand_read_open(input logic [7:0] a, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA0, ack); check(ack, {req, " dev ack"}, ack, 1);
    send_byte(a, ack); check(ack, {req, " waddr ack"}, ack, 1);
    i2c_start();
    send_byte(8'hA1, ack); check(ack, {req, " read dev ack"}, ack, 1);
  endtask

  task automatic t_reset();
    logic [7:0] b;
    check(sda_oe === 1'b0, "R1 oe after reset", sda_oe, 0);
    rand_read_open(8'h05, "R1");
    recv_byte(1'b0, b); i2c_stop();
    check(b == 8'hFF, "R1 erased content", b, 8'hFF);
  endtask

  task automatic t_no_start();
    bit ack;
    send_byte(8'hA0, ack);
    check(!ack, "R2 no ack without START", ack, 0);
    i2c_stop();
  endtask

  task automatic t_write_busy();
    bit ack;
    logic [7:0] b;
    write_byte(7'h10, 8'h5A, 1'b0, "R5");
    i2c_start(); send_byte(8'hA0, ack); i2c_stop();
    check(!ack, "R8 nack while busy", ack, 0);
    wait_busy();
    i2c_start(); send_byte(8'hA0, ack);
    check(ack, "R8 ack after busy", ack, 1);
    send_byte(8'h10, ack);
    i2c_start(); send_byte(8'hA1, ack);
    recv_byte(1'b0, b); i2c_stop();
    check(b == 8'h5A, "R6 committed byte", b, 8'h5A);
  endtask

  task automatic t_addr_msb();
    logic [7:0] b;
    write_byte(7'h10, 8'h33, 1'b1, "R5");
    wait_busy();
    rand_read_open(8'h10, "R5");
    recv_byte(1'b0, b); i2c_stop();
    check(b == 8'h33, "R5 word address bit7 ignored", b, 8'h33);
  endtask

  task automatic t_dev_match();
    bit ack;
    i2c_start(); send_byte(8'hB0, ack); i2c_stop();
    check(!ack, "R3 wrong device code", ack, 0);
    i2c_start(); send_byte(8'hAE, ack); i2c_stop();
    check(ack, "R3 don't-care bits", ack, 1);
  endtask

  task automatic t_restart_discard();
    bit ack;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hA0, ack); send_byte(8'h20, ack); send_byte(8'h99, ack);
    i2c_start();
    send_byte(8'hA1, ack);
    check(ack, "R7 no busy after abort", ack, 1);
    recv_byte(1'b0, b); i2c_stop();
    rand_read_open(8'h20, "R7");
    recv_byte(1'b0, b); i2c_stop();
    check(b == 8'hFF, "R7 aborted byte not written", b, 8'hFF);
  endtask

  task automatic t_seq_wrap();
    bit ack;
    logic [7:0] b0, b1, b2;
    write_byte(7'h7F, 8'hC1, 1'b0, "R9"); wait_busy();
    write_byte(7'h00, 8'h3C, 1'b0, "R9"); wait_busy();
    write_byte(7'h01, 8'h77, 1'b0, "R9"); wait_busy();
    rand_read_open(8'h7F, "R9");
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    i2c_stop();
    check(b0 == 8'hC1, "R9 first byte", b0, 8'hC1);
    check(b1 == 8'h3C, "R9 wrap 127 to 0", b1, 8'h3C);
    i2c_start(); send_byte(8'hA1, ack);
    recv_byte(1'b0, b2); i2c_stop();
    check(b2 == 8'h77, "R11 current address read", b2, 8'h77);
  endtask

  task automatic t_nack_stop();
    logic [7:0] b;
    rand_read_open(8'h7F, "R10");
    recv_byte(1'b0, b);
    oe_seen = 1'b0;
    watch_oe = 1'b1;
    recv_byte(1'b0, b);
    watch_oe = 1'b0;
    check(!oe_seen, "R10 quiet after nack", oe_seen, 0);
    check(b == 8'hFF, "R10 released line", b, 8'hFF);
    i2c_stop();
    rand_read_open(8'h00, "R10");
    recv_byte(1'b0, b); i2c_stop();
    check(b == 8'h3C, "R10 recovery after STOP", b, 8'h3C);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    t_reset();
    t_no_start();
    t_write_busy();
    t_addr_msb();
    t_dev_match();
    t_restart_discard();
    t_seq_wrap();
    t_nack_stop();
    check(viol == 0, "R4 oe stable while SCL high", viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog run incomplete actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule